// File: doc/BRIEF.md
# DRAM Bank Issue Gate

This block sits beside the bank queues of a DRAM controller and answers one question every cycle: may the request at the head of the candidate bank be sent to the DRAM now? The scheduler presents a bank number with the request's direction, whether it belongs to the oldest batch, a global age count, a random hold-off percentage and a fixed-delay mode flag. The block answers at once with `ready` and, when the answer is no, with a one-hot code that names the single reason.

The block holds all the timing state the decision needs. Each bank has a busy timer. The shared data bus has three timers: basic occupancy, the write turnaround and the read to a different rank. The block also keeps the rank it last drove and, for each rank, a sliding window of activate events. A 16-bit LFSR supplies the random value. When `issue` is asserted in a cycle where `ready` is high, the request is taken and every timer involved is loaded at that clock edge.

The checks are evaluated in a fixed priority order, and the first one that blocks names the cause. Cycles lost lower in the chain are therefore never reported while a higher check is already blocking.

Top module: `bank_issue_gate`

## Requirements
- R1: After reset every timer and activate window is clear, the last-driven rank is 0 and the LFSR holds `LFSR_SEED`. With random hold-off off, age 0 and any candidate, `ready` is 1 and `stall_cause` is 0.
- R2: `stall_cause` is one-hot or zero, and `ready` is 1 exactly when it is zero. The bits are: 0 bank busy, 1 random hold-off, 2 anti-starvation, 3 arbitration, 4 bus busy, 5 activate window full, 6 write turnaround, 7 read to a new rank. The checks run in the order 0, 1, fixed-delay exit, 2, 3, 4, 5, 6, 7.
- R3: An accepted issue loads the issued bank's timer with `BANK_BUSY`. That bank then reports bank busy for the next `BANK_BUSY` cycles, except in fixed-delay mode, which skips this check.
- R4: The LFSR shifts left every cycle out of reset, and its new bit 0 is the XOR of bits 15, 13, 12 and 10. Random hold-off blocks when `rand_pct` is 2 or more and the LFSR value modulo 100 is below `rand_pct`. A setting of 0 or 1 never blocks.
- R5: In fixed-delay mode the request is ready whenever neither bank busy nor random hold-off applies. This holds before any later check is made.
- R6: Anti-starvation blocks when `age_count` exceeds 2*`BANK_BUSY` and `cand_old` is 0.
- R7: An accepted issue loads the basic bus timer with `BASIC_BUSY`. While that timer equals `BASIC_BUSY` (the cycle just after an issue) the stall is arbitration. Any other nonzero value is bus busy.
- R8: Each rank records accepted issues in a window of the last `TFAW` cycles. The check blocks when the candidate rank's count in that window is at least `ACT_LIMIT`.
- R9: A read loads the write timer with `BASIC_BUSY`+`RD_WR_DELAY` and the new-rank timer with `BASIC_BUSY`+`RANK_DELAY`. A write loads both with `BASIC_BUSY`. A write is blocked while the write timer is nonzero. A read to a rank other than the last-driven rank is blocked while the new-rank timer is nonzero.
- R10: `issue` in a cycle where `ready` is 0 is ignored and loads no timer.
- R11: The rank of a bank is the bank number divided by `BANKS_PER_RANK`. An accepted issue makes that rank the last-driven rank.
- R12: Every timer counts down by one per cycle and stops at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_bank | input | BANK_W | Candidate bank number |
| cand_is_read | input | 1 | Candidate head is a read (0 = write) |
| cand_old | input | 1 | Candidate head belongs to the oldest batch |
| age_count | input | AGE_W | Global age count |
| rand_pct | input | 7 | Random hold-off percentage |
| fixed_mode | input | 1 | Fixed-delay mode |
| issue | input | 1 | Take the candidate if ready |
| ready | output | 1 | Candidate may issue this cycle |
| stall_cause | output | 8 | One-hot reason for not ready |

## Verification
`ready` and `stall_cause` depend combinationally on the current inputs and the stored state. The bench therefore drives each cycle's inputs at the falling edge and compares one time unit later, in the same cycle. An issue accepted at a rising edge first affects the outputs in the cycle that follows that edge. A timer loaded with N blocks for exactly the N cycles after the edge, and an activate stays in its window for `TFAW` cycles. The bench model updates its own timers at each rising edge, so every comparison lines up with the cycle in which the design's answer is due.

// File: rtl/bank_issue_gate.sv
module bank_issue_gate #(
  parameter int NUM_BANKS      = 8,
  parameter int BANKS_PER_RANK = 4,
  parameter int BANK_BUSY      = 6,
  parameter int BASIC_BUSY     = 2,
  parameter int RD_WR_DELAY    = 2,
  parameter int RANK_DELAY     = 1,
  parameter int TFAW           = 16,
  parameter int ACT_LIMIT      = 4,
  parameter int AGE_W          = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int NUM_RANKS = NUM_BANKS / BANKS_PER_RANK,
  localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int MAX_T     = BANK_BUSY + BASIC_BUSY + RD_WR_DELAY + RANK_DELAY,
  localparam int CNT_W     = $clog2(MAX_T + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] cand_bank,
  input  logic              cand_is_read,
  input  logic              cand_old,
  input  logic [AGE_W-1:0]  age_count,
  input  logic [6:0]        rand_pct,
  input  logic              fixed_mode,
  input  logic              issue,
  output logic              ready,
  output logic [7:0]        stall_cause
);
  localparam logic [AGE_W-1:0] AGE_LIMIT = AGE_W'(2 * BANK_BUSY);
  localparam logic [CNT_W-1:0] T_BANK = CNT_W'(BANK_BUSY);
  localparam logic [CNT_W-1:0] T_BASIC = CNT_W'(BASIC_BUSY);
  localparam logic [CNT_W-1:0] T_RD_WR = CNT_W'(BASIC_BUSY + RD_WR_DELAY);
  localparam logic [CNT_W-1:0] T_RD_NR = CNT_W'(BASIC_BUSY + RANK_DELAY);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  bank_cnt [NUM_BANKS];
  logic [CNT_W-1:0]  bus_cnt, wr_cnt, nr_cnt;
  logic [RANK_W-1:0] last_rank;
  logic [TFAW-1:0]   act_win [NUM_RANKS];
  logic [15:0]       lfsr;
  logic [BANK_W-1:0] rank_full;
  logic [RANK_W-1:0] cand_rank;
  logic              rnd_hit, act_full, fire;

  assign rank_full = cand_bank / BANK_W'(BANKS_PER_RANK);
  assign cand_rank = RANK_W'(rank_full);
  assign rnd_hit   = (rand_pct >= 7'd2) && ((lfsr % 16'd100) < 16'(rand_pct));
  assign act_full  = $countones(act_win[cand_rank]) >= ACT_LIMIT;

  always_comb begin
    stall_cause = '0;
    if (!fixed_mode && bank_cnt[cand_bank] != '0)          stall_cause[0] = 1'b1;
    else if (rnd_hit)                                       stall_cause[1] = 1'b1;
    else if (fixed_mode)                                    stall_cause    = '0;
    else if (age_count > AGE_LIMIT && !cand_old)            stall_cause[2] = 1'b1;
    else if (bus_cnt == T_BASIC)                            stall_cause[3] = 1'b1;
    else if (bus_cnt != '0)                                 stall_cause[4] = 1'b1;
    else if (act_full)                                      stall_cause[5] = 1'b1;
    else if (!cand_is_read && wr_cnt != '0)                 stall_cause[6] = 1'b1;
    else if (cand_is_read && cand_rank != last_rank && nr_cnt != '0)
                                                            stall_cause[7] = 1'b1;
  end

  assign ready = (stall_cause == '0);
  assign fire  = issue && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr      <= LFSR_SEED;
      bus_cnt   <= '0;
      wr_cnt    <= '0;
      nr_cnt    <= '0;
      last_rank <= '0;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (fire) begin
        bus_cnt   <= T_BASIC;
        wr_cnt    <= cand_is_read ? T_RD_WR : T_BASIC;
        nr_cnt    <= cand_is_read ? T_RD_NR : T_BASIC;
        last_rank <= cand_rank;
      end else begin
        if (bus_cnt != '0) bus_cnt <= bus_cnt - ONE;
        if (wr_cnt  != '0) wr_cnt  <= wr_cnt  - ONE;
        if (nr_cnt  != '0) nr_cnt  <= nr_cnt  - ONE;
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                                 bank_cnt[b] <= '0;
      else if (fire && cand_bank == BANK_W'(b))   bank_cnt[b] <= T_BANK;
      else if (bank_cnt[b] != '0)                 bank_cnt[b] <= bank_cnt[b] - ONE;
    end
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    always_ff @(posedge clk) begin
      if (!rst_n) act_win[r] <= '0;
      else        act_win[r] <= {act_win[r][TFAW-2:0], fire && cand_rank == RANK_W'(r)};
    end
  end
endmodule

// File: rtl/bank_issue_gate_chk.sv
module bank_issue_gate_chk #(
  parameter int AGE_W = 8,
  parameter int AGE_LIMIT = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue,
  input logic             ready,
  input logic [7:0]       stall_cause,
  input logic             fixed_mode,
  input logic [6:0]       rand_pct,
  input logic [AGE_W-1:0] age_count,
  input logic             cand_old
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stall_cause)); // R2
  AST_RAND_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rand_pct < 7'd2) |-> !stall_cause[1]); // R4
  AST_FIXED_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_mode && !stall_cause[1]) |-> ready); // R5
  AST_FIXED_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_mode |-> !stall_cause[0]); // R3
  AST_AGE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !fixed_mode) |-> (cand_old || int'(age_count) <= AGE_LIMIT)); // R6
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(issue && ready) && !fixed_mode) |-> !ready); // R7
endmodule

bind bank_issue_gate bank_issue_gate_chk #(.AGE_W(AGE_W), .AGE_LIMIT(2 * BANK_BUSY)) chk_i (
  .clk(clk), .rst_n(rst_n), .issue(issue), .ready(ready), .stall_cause(stall_cause),
  .fixed_mode(fixed_mode), .rand_pct(rand_pct), .age_count(age_count), .cand_old(cand_old)
);

// File: tb/bank_issue_gate_tb_top.sv
module bank_issue_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8, BPR = 4, NR = 2, BBUSY = 6, BASIC = 2, RWD = 2, RKD = 1;
  localparam int WIN = 16, ALIM = 4, WDOG = 100000;

  logic clk = 0, rst_n = 0;
  logic [2:0] cand_bank = 0;
  logic cand_is_read = 0, cand_old = 1, fixed_mode = 0, issue = 0;
  logic [7:0] age_count = 0;
  logic [6:0] rand_pct = 0;
  logic ready;
  logic [7:0] stall_cause;
  int checks = 0, failures = 0;

  int m_bank [NB];
  int m_bus = 0, m_wr = 0, m_nr = 0, m_last = 0;
  logic [WIN-1:0] m_win [NR];
  logic [15:0] m_lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_issue_gate dut_i (.clk(clk), .rst_n(rst_n), .cand_bank(cand_bank),
    .cand_is_read(cand_is_read), .cand_old(cand_old), .age_count(age_count),
    .rand_pct(rand_pct), .fixed_mode(fixed_mode), .issue(issue),
    .ready(ready), .stall_cause(stall_cause));

  function automatic logic [7:0] exp_cause();
    int rk = int'(cand_bank) / BPR;
    if (!fixed_mode && m_bank[cand_bank] != 0) return 8'h01;
    if (rand_pct >= 2 && (int'(m_lfsr) % 100) < int'(rand_pct)) return 8'h02;
    if (fixed_mode) return 8'h00;
    if (int'(age_count) > 2*BBUSY && !cand_old) return 8'h04;
    if (m_bus == BASIC) return 8'h08;
    if (m_bus != 0) return 8'h10;
    if ($countones(m_win[rk]) >= ALIM) return 8'h20;
    if (!cand_is_read && m_wr != 0) return 8'h40;
    if (cand_is_read && rk != m_last && m_nr != 0) return 8'h80;
    return 8'h00;
  endfunction

  function automatic string tag_of(logic [7:0] e);
    case (e)
      8'h01: return "R3";  8'h02: return "R4";  8'h04: return "R6";
      8'h08, 8'h10: return "R7";  8'h20: return "R8";
      8'h40, 8'h80: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic step(input logic [2:0] b, input logic rd, input logic old,
                      input logic [7:0] age, input logic [6:0] pct,
                      input logic fx, input logic iss, input string tag);
    logic [7:0] e;
    logic fire;
    int rk;
    @(negedge clk);
    cand_bank = b; cand_is_read = rd; cand_old = old; age_count = age;
    rand_pct = pct; fixed_mode = fx; issue = iss;
    #1;
    e = exp_cause();
    checks++;
    if (ready !== (e == 0) || stall_cause !== e) begin
      failures++;
      $display("FAIL %s (%s) ready=%0b cause=%b expected ready=%0b cause=%b",
               tag, tag_of(e), ready, stall_cause, (e == 0), e);
    end
    fire = iss && (e == 0);
    rk = int'(b) / BPR;
    @(posedge clk);
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    for (int i = 0; i < NB; i++) if (m_bank[i] > 0) m_bank[i]--;
    for (int r = 0; r < NR; r++) m_win[r] = {m_win[r][WIN-2:0], fire && rk == r};
    if (fire) begin
      m_bank[b] = BBUSY; m_bus = BASIC; m_last = rk;
      m_wr = rd ? BASIC + RWD : BASIC;
      m_nr = rd ? BASIC + RKD : BASIC;
    end else begin
      if (m_bus > 0) m_bus--;
      if (m_wr > 0) m_wr--;
      if (m_nr > 0) m_nr--;
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(3'd0, 1'b1, 1'b1, 8'd0, 7'd0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NB; i++) m_bank[i] = 0;
    for (int r = 0; r < NR; r++) m_win[r] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    for (int b = 0; b < NB; b++) step(3'(b), 1'(b % 2), 1'b0, 8'd0, 7'd0, 1'b0, 1'b0, "R1");

    // R3 R7 R12: issue bank 1, then watch it and the bus timer drain
    step(3'd1, 1'b0, 1'b1, 8'd0, 7'd0, 1'b0, 1'b1, "R7");
    for (int i = 0; i < 7; i++) step(3'd1, 1'b0, 1'b1, 8'd0, 7'd0, 1'b0, 1'b0, "R3");
    step(3'd2, 1'b0, 1'b1, 8'd0, 7'd0, 1'b0, 1'b1, "R7");
    step(3'd3, 1'b0, 1'b1, 8'd0, 7'd0, 1'b0, 1'b0, "R7");
    step(3'd3, 1'b0, 1'b1, 8'd0, 7'd0, 1'b0, 1'b0, "R12");
    idle(8, "R12");

    // R9 R11: read on rank 0, then a write and a rank 1 read
    step(3'd0, 1'b1, 1'b1, 8'd0, 7'd0, 1'b0, 1'b1, "R9");
    step(3'd5, 1'b0, 1'b1, 8'd0, 7'd0, 1'b0, 1'b0, "R7");
    step(3'd5, 1'b0, 1'b1, 8'd0, 7'd0, 1'b0, 1'b0, "R7");
    step(3'd5, 1'b0, 1'b1, 8'd0, 7'd0, 1'b0, 1'b0, "R9");
    step(3'd5, 1'b1, 1'b1, 8'd0, 7'd0, 1'b0, 1'b0, "R11");
    step(3'd1, 1'b1, 1'b1, 8'd0, 7'd0, 1'b0, 1'b0, "R11");
    idle(8, "R12");

    // R8: four writes to rank 0, then a fifth blocked by the window
    for (int k = 0; k < 4; k++) begin
      step(3'(k), 1'b0, 1'b1, 8'd0, 7'd0, 1'b0, 1'b1, "R8");
      step(3'd4, 1'b0, 1'b1, 8'd0, 7'd0, 1'b0, 1'b0, "R8");
      step(3'd4, 1'b0, 1'b1, 8'd0, 7'd0, 1'b0, 1'b0, "R8");
    end
    step(3'd0, 1'b0, 1'b1, 8'd0, 7'd0, 1'b0, 1'b1, "R8");
    step(3'd4, 1'b0, 1'b1, 8'd0, 7'd0, 1'b0, 1'b1, "R8");
    idle(20, "R8");

    // R6: age gate
    step(3'd2, 1'b1, 1'b0, 8'd12, 7'd0, 1'b0, 1'b0, "R6");
    step(3'd2, 1'b1, 1'b0, 8'd13, 7'd0, 1'b0, 1'b0, "R6");
    step(3'd2, 1'b1, 1'b1, 8'd200, 7'd0, 1'b0, 1'b0, "R6");

    // R4 R10: full hold-off with issue asserted must load nothing
    for (int i = 0; i < 4; i++) step(3'd6, 1'b0, 1'b1, 8'd0, 7'd100, 1'b0, 1'b1, "R10");
    step(3'd6, 1'b0, 1'b1, 8'd0, 7'd1, 1'b0, 1'b0, "R10");
    for (int i = 0; i < 20; i++) step(3'd6, 1'b0, 1'b1, 8'd0, 7'd50, 1'b0, 1'b0, "R4");

    // R5: fixed mode issues back to back on one bank
    for (int i = 0; i < 6; i++) step(3'd7, 1'b1, 1'b0, 8'd99, 7'd0, 1'b1, 1'b1, "R5");
    idle(8, "R12");

    for (int i = 0; i < 4000; i++) begin
      logic [6:0] pct = ($urandom % 8 == 0) ? 7'(2 + $urandom % 60) : 7'($urandom % 2);
      step(3'($urandom % NB), 1'($urandom % 2), ($urandom % 10) < 7,
           8'($urandom % 16), pct, ($urandom % 10) == 0, ($urandom % 10) < 8, "R2");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule